// File: doc/BRIEF.md
# Sprite Attribute DMA Engine

This block moves one 256-byte page from the processor's address space into the 256-byte sprite attribute memory, and holds the processor off while it does so. Software starts a copy by writing a page number to the trigger register. The engine then takes over the processor bus. It alternates one read cycle with one write cycle until all 256 bytes are stored, and it asserts a stall output for the whole copy.

The block also owns the attribute address pointer and a single-byte data port. A data-port write stores its byte at the pointer and then advances the pointer. A DMA copy begins storing at the current pointer and wraps around the 256-entry memory. The pointer is not changed by the copy. The stall lasts 513 cycles, or 514 cycles when the trigger write falls on an odd processor cycle, as signalled by the parity input.

The memory write port has no back-pressure: the memory takes a write in every cycle in which `mem_wr_en` is high. The bus read returns its data within the same cycle it is issued. Register writes are single-cycle strobes, and at most one strobe is high in any cycle.

Top module: `sprite_dma_engine`

## Requirements
- R1: A trigger write while idle takes `cpu_wdata` as the source page P. The engine then issues exactly 256 bus reads, at addresses (P << 8) + i for i = 0 to 255 in ascending order.
- R2: Each trigger produces exactly 256 DMA memory writes. Write i carries the byte returned by read i.
- R3: DMA write i goes to memory address (pointer + i) mod 256, where pointer is the value held when the trigger was accepted.
- R4: The stall stays high for 513 consecutive cycles when `odd_cycle` is 0 in the trigger cycle, and for 514 cycles when it is 1.
- R5: The stall rises in the cycle after the trigger write. It falls in the cycle after the 256th DMA write.
- R6: The copy has one lead cycle, then one alignment cycle only when odd, then 256 pairs of a read cycle followed by a write cycle. Bus reads happen only while stalled, and no cycle carries both a read and a write.
- R7: A data-port write while idle stores `cpu_wdata` at the pointer in that same cycle. The pointer then increments, wrapping from 255 to 0. A pointer write while idle loads `cpu_wdata` into the pointer.
- R8: Trigger, pointer and data-port writes that arrive while stalled are ignored. They produce no memory write, no pointer change and no second copy.
- R9: After a copy ends, the pointer holds the value it had before the trigger.
- R10: After reset the stall is low, the pointer is 0, and no read or write is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_wr | input | 1 | Load the attribute pointer from cpu_wdata |
| data_wr | input | 1 | Data-port write of cpu_wdata at the pointer |
| trig_wr | input | 1 | Trigger write; cpu_wdata is the source page |
| cpu_wdata | input | 8 | Processor write data |
| odd_cycle | input | 1 | High when the current processor cycle is odd |
| stall | output | 1 | Processor hold while a copy runs |
| bus_rd_en | output | 1 | Bus read strobe of the engine |
| bus_rd_addr | output | 16 | Bus read address |
| bus_rd_data | input | 8 | Bus read data, valid in the read cycle |
| mem_wr_en | output | 1 | Attribute memory write enable |
| mem_wr_addr | output | 8 | Attribute memory write address |
| mem_wr_data | output | 8 | Attribute memory write data |
| ptr_out | output | 8 | Current attribute pointer |

## Verification
A data-port write shows on the memory port in the same cycle as its strobe. The pointer shows the increment one cycle later. After a trigger at edge T, the stall is sampled high at the falling edge after T. Read i falls in cycle T+2+odd+2i and write i in the cycle after it, and the stall is expected to fall after 513 or 514 high samples. The bench drives strobes just after a rising edge and samples every output at the falling edge. The monitor pops expected reads and writes from queues in arrival order, so an extra, missing, reordered or ignored-but-acted-on transfer shows up as a mismatch or an empty-queue failure.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_LEAD  = 3'd1,
    SQ_ALIGN = 3'd2,
    SQ_READ  = 3'd3,
    SQ_WRITE = 3'd4
  } seq_state_t;
endpackage

// File: rtl/sdma_ptr.sv
module sdma_ptr #(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              bump,
  input  logic [MEM_AW-1:0] din,
  output logic [MEM_AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= din;
    else if (bump) ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/sdma_seq.sv
module sdma_seq
  import sdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] page_in,
  input  logic              odd_in,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [MEM_AW-1:0] idx,
  output logic [DATA_W-1:0] wr_data
);
  localparam int PAGE_W = ADDR_W - MEM_AW;

  seq_state_t        state;
  logic [PAGE_W-1:0] page_q;
  logic              odd_q;
  logic [MEM_AW-1:0] cnt;
  logic [DATA_W-1:0] hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      page_q <= '0;
      odd_q  <= 1'b0;
      cnt    <= '0;
      hold   <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (start) begin
          page_q <= page_in[PAGE_W-1:0];
          odd_q  <= odd_in;
          cnt    <= '0;
          state  <= SQ_LEAD;
        end
        SQ_LEAD:  state <= odd_q ? SQ_ALIGN : SQ_READ;
        SQ_ALIGN: state <= SQ_READ;
        SQ_READ: begin
          hold  <= rd_data;
          state <= SQ_WRITE;
        end
        SQ_WRITE: begin
          cnt   <= cnt + 1'b1;
          state <= (cnt == {MEM_AW{1'b1}}) ? SQ_IDLE : SQ_READ;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign busy    = (state != SQ_IDLE);
  assign rd_en   = (state == SQ_READ);
  assign rd_addr = {page_q, cnt};
  assign wr_en   = (state == SQ_WRITE);
  assign idx     = cnt;
  assign wr_data = hold;
endmodule

// File: rtl/sprite_dma_engine.sv
module sprite_dma_engine #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_wr,
  input  logic              data_wr,
  input  logic              trig_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              odd_cycle,
  output logic              stall,
  output logic              bus_rd_en,
  output logic [ADDR_W-1:0] bus_rd_addr,
  input  logic [DATA_W-1:0] bus_rd_data,
  output logic              mem_wr_en,
  output logic [MEM_AW-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic [MEM_AW-1:0] ptr_out
);
  logic              busy;
  logic              dma_wr;
  logic [MEM_AW-1:0] dma_idx;
  logic [DATA_W-1:0] dma_data;
  logic              port_wr;
  logic              port_ld;

  assign port_wr = data_wr && !busy;
  assign port_ld = ptr_wr && !busy;

  sdma_ptr #(.MEM_AW(MEM_AW)) u_ptr (
    .clk  (clk),
    .rst_n(rst_n),
    .load (port_ld),
    .bump (port_wr),
    .din  (cpu_wdata[MEM_AW-1:0]),
    .ptr  (ptr_out)
  );

  sdma_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (trig_wr),
    .page_in(cpu_wdata),
    .odd_in (odd_cycle),
    .rd_data(bus_rd_data),
    .busy   (busy),
    .rd_en  (bus_rd_en),
    .rd_addr(bus_rd_addr),
    .wr_en  (dma_wr),
    .idx    (dma_idx),
    .wr_data(dma_data)
  );

  assign stall       = busy;
  assign mem_wr_en   = dma_wr || port_wr;
  assign mem_wr_addr = dma_wr ? (ptr_out + dma_idx) : ptr_out;
  assign mem_wr_data = dma_wr ? dma_data : cpu_wdata;
endmodule

// File: rtl/sdma_checker.sv
module sdma_checker #(
  parameter int MEM_AW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig_wr,
  input logic              data_wr,
  input logic              stall,
  input logic              bus_rd_en,
  input logic              mem_wr_en,
  input logic [MEM_AW-1:0] ptr_out
);
  AST_STALL_AFTER_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_wr && !stall) |=> stall);                                    // R5
  AST_RD_ONLY_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_en |-> stall);                                              // R6
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd_en && mem_wr_en));                                        // R6
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && stall) |-> $past(bus_rd_en));                        // R2
  AST_PTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(ptr_out));                                       // R9
  AST_PORT_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !stall) |=> ptr_out == $past(ptr_out) + 1'b1);         // R7
endmodule

bind sprite_dma_engine sdma_checker #(.MEM_AW(MEM_AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .trig_wr  (trig_wr),
  .data_wr  (data_wr),
  .stall    (stall),
  .bus_rd_en(bus_rd_en),
  .mem_wr_en(mem_wr_en),
  .ptr_out  (ptr_out)
);

// File: tb/sprite_dma_engine_tb.sv
module sprite_dma_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ptr_wr = 1'b0, data_wr = 1'b0, trig_wr = 1'b0;
  logic [7:0]  cpu_wdata = 8'h00;
  logic        odd_cycle = 1'b0;
  logic        stall, bus_rd_en, mem_wr_en;
  logic [15:0] bus_rd_addr;
  logic [7:0]  bus_rd_data, mem_wr_addr, mem_wr_data, ptr_out;

  int checks = 0;
  int errors = 0;
  int exp_stall = 0;
  int run_len = 0;
  logic [15:0] rd_q[$];
  logic [15:0] wr_q[$];

  always #2 clk = ~clk;

  function automatic logic [7:0] src_byte(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  assign bus_rd_data = src_byte(bus_rd_addr);

  sprite_dma_engine u_dut (
    .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .data_wr(data_wr),
    .trig_wr(trig_wr), .cpu_wdata(cpu_wdata), .odd_cycle(odd_cycle),
    .stall(stall), .bus_rd_en(bus_rd_en), .bus_rd_addr(bus_rd_addr),
    .bus_rd_data(bus_rd_data), .mem_wr_en(mem_wr_en),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .ptr_out(ptr_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pops at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_rd_en) begin
        if (rd_q.size() == 0) check("R1 unexpected read", {16'h0, bus_rd_addr}, 32'hFFFFFFFF);
        else check("R1 read address", {16'h0, bus_rd_addr}, {16'h0, rd_q.pop_front()});
      end
      if (mem_wr_en) begin
        if (wr_q.size() == 0) check("R8 unexpected write", {16'h0, mem_wr_addr, mem_wr_data}, 32'hFFFFFFFF);
        else check("R2 R3 write addr/data", {16'h0, mem_wr_addr, mem_wr_data}, {16'h0, wr_q.pop_front()});
      end
      if (stall) run_len++;
      else if (run_len > 0) begin
        check("R4 stall length", run_len, exp_stall);
        run_len = 0;
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic set_ptr(input logic [7:0] v);
    ptr_wr = 1'b1; cpu_wdata = v; tick(); ptr_wr = 1'b0;
  endtask

  task automatic port_write(input logic [7:0] v, input logic [7:0] at);
    wr_q.push_back({at, v});
    data_wr = 1'b1; cpu_wdata = v; tick(); data_wr = 1'b0;
  endtask

  task automatic run_dma(input logic [7:0] page, input logic odd, input logic [7:0] p0, input bit poke);
    for (int i = 0; i < 256; i++) begin
      rd_q.push_back({page, i[7:0]});
      wr_q.push_back({p0 + i[7:0], src_byte({page, i[7:0]})});
    end
    exp_stall = odd ? 514 : 513;
    check("R5 stall low before trigger", stall, 1'b0);
    trig_wr = 1'b1; cpu_wdata = page; odd_cycle = odd;
    tick();
    trig_wr = 1'b0; odd_cycle = ~odd;
    @(negedge clk);
    check("R5 stall high cycle after trigger", stall, 1'b1);
    if (poke) begin
      tick();
      trig_wr = 1'b1; cpu_wdata = 8'h33; odd_cycle = 1'b1; tick(); trig_wr = 1'b0;
      data_wr = 1'b1; cpu_wdata = 8'h77; tick(); data_wr = 1'b0;
      ptr_wr = 1'b1; cpu_wdata = 8'h11; tick(); ptr_wr = 1'b0;
    end
    while (stall) tick();
    @(negedge clk);
    check("R2 all writes seen", wr_q.size(), 0);
    check("R1 all reads seen", rd_q.size(), 0);
    check("R9 pointer kept", ptr_out, p0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 stall at reset", stall, 1'b0);
    check("R10 pointer at reset", ptr_out, 8'h00);
    check("R10 no read at reset", bus_rd_en, 1'b0);
    check("R10 no write at reset", mem_wr_en, 1'b0);
    tick(); rst_n = 1'b1; tick();

    // R7: data port with wrap
    set_ptr(8'hFE);
    check("R7 pointer load", ptr_out, 8'hFE);
    port_write(8'h12, 8'hFE);
    port_write(8'h34, 8'hFF);
    port_write(8'h56, 8'h00);
    @(negedge clk);
    check("R7 pointer wrapped", ptr_out, 8'h01);

    // even cycle, pointer 0
    set_ptr(8'h00);
    run_dma(8'h02, 1'b0, 8'h00, 1'b0);
    // odd cycle, pointer mid-range (R3 wrap of destination)
    set_ptr(8'h80);
    run_dma(8'hC3, 1'b1, 8'h80, 1'b0);
    // R8: writes arriving while stalled are ignored
    set_ptr(8'h05);
    run_dma(8'h7F, 1'b0, 8'h05, 1'b1);
    repeat (4) tick();
    @(negedge clk);
    check("R8 no second copy", stall, 1'b0);
    check("R8 pointer untouched", ptr_out, 8'h05);
    port_write(8'h9A, 8'h05);
    @(negedge clk);
    check("R7 port after copy", ptr_out, 8'h06);
    check("R2 queue drained", wr_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule